// File: doc/BRIEF.md
# Two-Hand Clock Frame Reclaimer

This block does the bookkeeping for page replacement over a fixed pool of physical page frames. It holds three state bits for each frame: recently used, modified, and pending. Pending means the frame is already on its way to the free list. A stream of reference events, each naming a frame, sets these bits. A fault consumer draws free frames from a small first-in first-out free list.

Two hands sweep the frames in a ring, one step per enabled cycle. The trailing hand clears the used bit of the frame it passes. The leading hand runs a fixed gap ahead of it. When the leading hand finds a frame whose used bit is still clear, it reclaims that frame.

A clean frame goes straight onto the free list. A modified frame is first offered on a write-back port. Only after that transfer is acknowledged does its modified bit clear and the frame join the free list. The sweep pauses while the free list is full and while a write-back is outstanding.

Both the write-back port and the fault port are valid/ready. A transfer happens on a clock edge where both signals are high. The write-back source holds `wb_valid` and `wb_frame` steady until `wb_ready` is seen. The fault port raises `fault_ready` only while the free list holds a frame, so a fault request with an empty list simply waits. Reference events are always accepted and have no ready signal.

Top module: `clock_page_reclaim`

## Requirements
- R1: A cycle with `ref_valid` high sets the used bit of `ref_frame`. While that bit is set, the leading hand passes over the frame without reclaiming it.
- R2: A reference with `ref_write` high also sets the frame's modified bit, in addition to its used bit.
- R3: Reset puts the trailing hand at frame 0 and the leading hand at frame GAP (default 16), with the hands wrapping modulo FRAMES (default 64). Both hands advance by one frame on each cycle where `sweep_en` is high and the sweep is not paused. The trailing hand clears the used bit of the frame it leaves.
- R4: When the leading hand finds a frame that is not used and not pending, it reclaims that frame and marks it pending. A pending frame is never reclaimed again until a fault takes it.
- R5: A reclaimed modified frame is presented as `wb_valid` with `wb_frame`. The frame number stays stable until `wb_ready` is seen, and the sweep pauses meanwhile. On the accepting edge the modified bit clears and the frame is appended to the free list.
- R6: The free list is first-in first-out in reclaim order and holds DEPTH frames (default 8). The sweep pauses while the list is full.
- R7: `fault_ready` is high exactly when the free list is non-empty, and `fault_frame` shows its oldest entry. A transfer removes that frame and clears its used, modified and pending bits.
- R8: After reset the free list is empty, no write-back is offered, and every frame's bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sweep_en | input | 1 | Allows the hands to advance |
| ref_valid | input | 1 | Reference event present this cycle |
| ref_frame | input | FW | Frame number being referenced |
| ref_write | input | 1 | Reference is a write |
| fault_valid | input | 1 | Fault requests a free frame |
| fault_ready | output | 1 | A free frame is available |
| fault_frame | output | FW | Frame handed out |
| wb_valid | output | 1 | Write-back request for a modified frame |
| wb_frame | output | FW | Frame to write back |
| wb_ready | input | 1 | Write-back accepted |

## Verification
The bench fills the free list with no consumer attached. It checks that exactly DEPTH frames in hand order come out and that the sweep resumes at the next frame. A design that kept sweeping while full would drop or overwrite frames.

It then references every fifth frame and writes two frames, one on each side of the leading hand's start point. It runs three full laps against an arithmetic prediction of the grant order. Frames the trailing hand has not yet reached must be skipped in the first lap, while frames it already cleared must be taken. Each written frame must appear on the write-back port exactly once, with the write-back held for several cycles.

A design with inverted hand roles, a missing pending bit or a modified bit that never clears would show up as a wrong, duplicated or extra entry in these sequences.

// File: rtl/clk_pr_pkg.sv
package clk_pr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE      = 2'd0,
    ACT_FREE      = 2'd1,
    ACT_WRITEBACK = 2'd2
  } reclaim_act_t;
endpackage

// File: rtl/clk_pr_fifo.sv
module clk_pr_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   count;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R6: the sweep must never push into a full list
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R7: a grant is only taken from a non-empty list
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/clk_pr_frame_bits.sv
module clk_pr_frame_bits #(
  parameter int FRAMES = 64,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_v,
  input  logic [FW-1:0] ref_f,
  input  logic          ref_w,
  input  logic          clr_v,
  input  logic [FW-1:0] clr_f,
  input  logic          mark_v,
  input  logic [FW-1:0] mark_f,
  input  logic          wbd_v,
  input  logic [FW-1:0] wbd_f,
  input  logic          grant_v,
  input  logic [FW-1:0] grant_f,
  output logic [FRAMES-1:0] used,
  output logic [FRAMES-1:0] dirty,
  output logic [FRAMES-1:0] pend
);
  for (genvar i = 0; i < FRAMES; i++) begin : g_frame
    localparam logic [FW-1:0] ID = FW'(i);
    logic hit_ref, hit_clr, hit_mark, hit_wbd, hit_grant;
    assign hit_ref   = ref_v   && (ref_f   == ID);
    assign hit_clr   = clr_v   && (clr_f   == ID);
    assign hit_mark  = mark_v  && (mark_f  == ID);
    assign hit_wbd   = wbd_v   && (wbd_f   == ID);
    assign hit_grant = grant_v && (grant_f == ID);

    always_ff @(posedge clk) begin
      if (rst) begin
        used[i]  <= 1'b0;
        dirty[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        if (hit_ref)                     used[i] <= 1'b1;
        else if (hit_clr || hit_grant)   used[i] <= 1'b0;
        if (hit_ref && ref_w)            dirty[i] <= 1'b1;
        else if (hit_wbd || hit_grant)   dirty[i] <= 1'b0;
        if (hit_mark)                    pend[i] <= 1'b1;
        else if (hit_grant)              pend[i] <= 1'b0;
      end
    end
  end

  // R1: a reference always leaves the frame marked used
  a_r1_ref_sets_used: assert property (@(posedge clk) disable iff (rst)
    ref_v |=> used[$past(ref_f)]);
  // R2: a write always leaves the frame marked modified
  a_r2_write_sets_dirty: assert property (@(posedge clk) disable iff (rst)
    (ref_v && ref_w) |=> dirty[$past(ref_f)]);
  // R4: a frame already pending is never reclaimed a second time
  a_r4_no_double_reclaim: assert property (@(posedge clk) disable iff (rst)
    mark_v |-> !pend[mark_f]);
endmodule

// File: rtl/clk_pr_sweep.sv
module clk_pr_sweep
  import clk_pr_pkg::*;
#(
  parameter int FRAMES = 64,
  parameter int GAP    = 16,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sweep_en,
  input  logic          fifo_full,
  input  logic          lead_used,
  input  logic          lead_dirty,
  input  logic          lead_pend,
  input  logic          wb_ready,
  output logic [FW-1:0] trail,
  output logic [FW-1:0] lead,
  output logic          adv,
  output logic          push_v,
  output logic [FW-1:0] push_f,
  output logic          mark_v,
  output logic          wb_valid,
  output logic [FW-1:0] wb_frame,
  output logic          wb_done
);
  reclaim_act_t act;

  assign lead    = trail + FW'(GAP);
  assign adv     = sweep_en && !fifo_full && !wb_valid;
  assign wb_done = wb_valid && wb_ready;

  always_comb begin
    act = ACT_NONE;
    if (adv && !lead_used && !lead_pend)
      act = lead_dirty ? ACT_WRITEBACK : ACT_FREE;
  end

  assign mark_v = (act != ACT_NONE);
  assign push_v = (act == ACT_FREE) || wb_done;
  assign push_f = wb_done ? wb_frame : lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      trail    <= '0;
      wb_valid <= 1'b0;
      wb_frame <= '0;
    end else begin
      if (adv) trail <= trail + 1'b1;
      if (act == ACT_WRITEBACK) begin
        wb_valid <= 1'b1;
        wb_frame <= lead;
      end else if (wb_done) begin
        wb_valid <= 1'b0;
      end
    end
  end

  // R5: an unaccepted write-back keeps its frame number
  a_r5_wb_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_frame)));
  // R5: the hands stay put while a write-back is outstanding
  a_r5_sweep_paused: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> $stable(trail));
  // R6: the hands stay put while the free list is full
  a_r6_full_pause: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> $stable(trail));
endmodule

// File: rtl/clock_page_reclaim.sv
module clock_page_reclaim #(
  parameter int FRAMES = 64,
  parameter int GAP    = 16,
  parameter int DEPTH  = 8,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sweep_en,
  input  logic          ref_valid,
  input  logic [FW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          fault_valid,
  output logic          fault_ready,
  output logic [FW-1:0] fault_frame,
  output logic          wb_valid,
  output logic [FW-1:0] wb_frame,
  input  logic          wb_ready
);
  logic [FRAMES-1:0] used, dirty, pend;
  logic [FW-1:0] trail, lead, push_f;
  logic adv, push_v, mark_v, wb_done, fifo_full, fifo_empty, grant;

  assign fault_ready = !fifo_empty;
  assign grant       = fault_valid && fault_ready;

  clk_pr_frame_bits #(.FRAMES(FRAMES)) u_bits (
    .clk(clk), .rst(rst),
    .ref_v(ref_valid), .ref_f(ref_frame), .ref_w(ref_write),
    .clr_v(adv), .clr_f(trail),
    .mark_v(mark_v), .mark_f(lead),
    .wbd_v(wb_done), .wbd_f(wb_frame),
    .grant_v(grant), .grant_f(fault_frame),
    .used(used), .dirty(dirty), .pend(pend)
  );

  clk_pr_sweep #(.FRAMES(FRAMES), .GAP(GAP)) u_sweep (
    .clk(clk), .rst(rst), .sweep_en(sweep_en), .fifo_full(fifo_full),
    .lead_used(used[lead]), .lead_dirty(dirty[lead]), .lead_pend(pend[lead]),
    .wb_ready(wb_ready), .trail(trail), .lead(lead), .adv(adv),
    .push_v(push_v), .push_f(push_f), .mark_v(mark_v),
    .wb_valid(wb_valid), .wb_frame(wb_frame), .wb_done(wb_done)
  );

  clk_pr_fifo #(.W(FW), .DEPTH(DEPTH)) u_free (
    .clk(clk), .rst(rst), .push(push_v), .push_data(push_f),
    .pop(grant), .head(fault_frame), .full(fifo_full), .empty(fifo_empty)
  );

  // R7: a granted frame leaves the pending set on the next edge
  a_r7_grant_releases: assert property (@(posedge clk) disable iff (rst)
    grant |=> !pend[$past(fault_frame)]);
endmodule

// File: tb/test_clock_page_reclaim.sv
module test_clock_page_reclaim;
  localparam int FRAMES = 64;
  localparam int GAP    = 16;
  localparam int DEPTH  = 8;
  localparam int FW     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sweep_en = 1'b0, ref_valid = 1'b0, ref_write = 1'b0;
  logic fault_valid = 1'b0, wb_ready = 1'b0;
  logic [FW-1:0] ref_frame = '0;
  logic fault_ready, wb_valid;
  logic [FW-1:0] fault_frame, wb_frame;

  always #10 clk = ~clk;

  clock_page_reclaim #(.FRAMES(FRAMES), .GAP(GAP), .DEPTH(DEPTH)) i_clock_page_reclaim (
    .clk(clk), .rst(rst), .sweep_en(sweep_en), .ref_valid(ref_valid),
    .ref_frame(ref_frame), .ref_write(ref_write), .fault_valid(fault_valid),
    .fault_ready(fault_ready), .fault_frame(fault_frame), .wb_valid(wb_valid),
    .wb_frame(wb_frame), .wb_ready(wb_ready)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit pop_en = 0;
  int wbwait = 0;
  bit wb_hold = 0;
  logic [FW-1:0] wb_prev = '0;
  int grants[$];
  int wbs[$];
  int expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input int rf, input bit rw);
    @(negedge clk);
    ref_valid   = rv;
    ref_frame   = rf[FW-1:0];
    ref_write   = rw;
    fault_valid = pop_en;
    wb_ready    = wb_valid && (wbwait >= 3);
    #1;
    if (wb_valid && wb_hold)
      chk(wb_frame == wb_prev, "R5 wb_frame held", int'(wb_frame), int'(wb_prev));
    if (fault_valid && fault_ready) grants.push_back(int'(fault_frame));
    if (wb_valid && wb_ready) begin
      wbs.push_back(int'(wb_frame));
      wbwait  = 0;
      wb_hold = 0;
    end else if (wb_valid) begin
      wbwait++;
      wb_hold = 1;
      wb_prev = wb_frame;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; sweep_en = 1'b0; pop_en = 0;
    repeat (4) cyc(0, 0, 0);
    rst = 1'b0;
    grants.delete(); wbs.delete();
    wbwait = 0; wb_hold = 0;
  endtask

  function automatic bit touched(input int f);
    return (f % 5 == 0) || f == 3 || f == 20;
  endfunction

  initial begin
    do_reset();
    // R8: reset state
    chk(fault_ready == 1'b0, "R8 free list empty", int'(fault_ready), 0);
    chk(wb_valid == 1'b0, "R8 no write-back", int'(wb_valid), 0);

    // R7: fault on empty list waits
    pop_en = 1;
    repeat (6) cyc(0, 0, 0);
    chk(grants.size() == 0, "R7 empty list grants nothing", grants.size(), 0);

    // R6: fill without consumer, then drain
    pop_en = 0; sweep_en = 1'b1;
    repeat (20) cyc(0, 0, 0);
    chk(fault_ready == 1'b1, "R6 list holds frames", int'(fault_ready), 1);
    sweep_en = 1'b0; pop_en = 1;
    repeat (12) cyc(0, 0, 0);
    chk(grants.size() == DEPTH, "R6 stall at full", grants.size(), DEPTH);
    for (int i = 0; i < DEPTH && i < grants.size(); i++)
      chk(grants[i] == GAP + i, "R6 fifo order", grants[i], GAP + i);
    chk(fault_ready == 1'b0, "R7 ready low once drained", int'(fault_ready), 0);

    // R3: sweep resumes at the next frame after the stall
    grants.delete(); pop_en = 0; sweep_en = 1'b1;
    cyc(0, 0, 0);
    sweep_en = 1'b0; pop_en = 1;
    repeat (3) cyc(0, 0, 0);
    chk(grants.size() == 1, "R3 one step one frame", grants.size(), 1);
    if (grants.size() > 0)
      chk(grants[0] == GAP + DEPTH, "R3 resume frame", grants[0], GAP + DEPTH);

    // R1 R2 R4 R5: references then three laps
    do_reset();
    cyc(1, 3, 1);
    cyc(1, 20, 1);
    for (int f = 0; f < FRAMES; f += 5) cyc(1, f, 0);
    cyc(0, 0, 0);
    expq.delete();
    for (int lap = 0; lap < 3; lap++)
      for (int a = 0; a < FRAMES; a++) begin
        int f;
        f = (GAP + a) % FRAMES;
        if (!(lap == 0 && touched(f) && f > a)) expq.push_back(f);
      end
    pop_en = 1; sweep_en = 1'b1;
    for (int n = 0; n < 4000 && grants.size() < expq.size(); n++) cyc(0, 0, 0);
    sweep_en = 1'b0; pop_en = 0;
    chk(grants.size() >= expq.size(), "R4 grant count", grants.size(), expq.size());
    for (int i = 0; i < expq.size() && i < grants.size(); i++)
      chk(grants[i] == expq[i], "R1 R4 grant order", grants[i], expq[i]);
    chk(wbs.size() == 2, "R5 write-back count", wbs.size(), 2);
    if (wbs.size() > 0) chk(wbs[0] == 3, "R2 first write-back", wbs[0], 3);
    if (wbs.size() > 1) chk(wbs[1] == 20, "R2 second write-back", wbs[1], 20);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule